// File: doc/BRIEF.md
# Masked SIMD Branch Sequencer

This block is the control side of a small lockstep processor array. It holds a row of processing elements, each with one data word and a mask bit, and broadcasts single operations to them. A masked element skips a broadcast and keeps its word. The central command is a data-parallel two-way branch. First every element that is live evaluates a comparison against a broadcast constant. Elements that fail the test are masked, and the rest run the first operation. The mask is then inverted, but only inside the set that was live when the branch began, and the newly live elements run the second operation. Finally the mask that held before the branch is put back.

The mask history sits on a small stack. A separate push command narrows the live set by a test, and a pop command restores it. This lets a branch run inside an enclosing conditional region. Element storage cannot be written from outside the block. Words change only through broadcast operations. A combinational readback port shows one element's word and its mask bit.

Top module: `simd_branch_seq`

## Requirements
- R1: After reset every element word is 0, no element is masked, no mask is saved, and `busy`, `done` and `err` are 0.
- R2: A `cmd`=0 (execute) start applies `then_op` with `op_imm` to every unmasked element at the start edge. Masked elements keep their word. `done` is high in the following cycle.
- R3: Operation codes: 0 keep, 1 load `op_imm`, 2 load `op_imm` plus the element index, 3 add `op_imm`, 4 subtract `op_imm`, 5 xor `op_imm`, 6 and 7 keep. All results wrap modulo 2^DATA_W.
- R4: Test codes on an element word w: `cond_sel` 0 is w == `cond_imm`, 1 is w != `cond_imm`, 2 is w < `cond_imm` unsigned, 3 is w >= `cond_imm` unsigned.
- R5: A `cmd`=1 (branch) start makes each element that is unmasked at start and passes the test apply `then_op`. Each element that is unmasked at start and fails the test applies `else_op`. Both use `op_imm`. Elements masked at start are unchanged.
- R6: When a branch completes, every mask bit equals its value before the branch.
- R7: After an accepted branch start, `busy` is high for exactly 5 cycles (test, first arm, flip, second arm, restore). `done` is then high for exactly one cycle with `busy` low. Every other command leaves `busy` low and raises `done` in the cycle after its start.
- R8: A start while `busy` is high is ignored.
- R9: A `cmd`=2 (push) start saves the mask and then masks every element that fails the test. A `cmd`=3 (pop) start restores the most recently saved mask.
- R10: Push or branch with STK_D masks saved, or pop with none saved, changes no word and no mask. It completes as a one-cycle command and sets `err`, which stays high until reset.
- R11: `rd_data` and `rd_masked` show the word and mask bit of element `rd_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command start strobe |
| cmd | input | 2 | Command kind: 0 execute, 1 branch, 2 push, 3 pop |
| cond_sel | input | 2 | Test selector |
| cond_imm | input | DATA_W | Test constant |
| then_op | input | 3 | Operation for execute and the first branch arm |
| else_op | input | 3 | Operation for the second branch arm |
| op_imm | input | DATA_W | Operation constant |
| rd_idx | input | IDX_W | Element selected for readback |
| rd_data | output | DATA_W | Word of selected element |
| rd_masked | output | 1 | Mask bit of selected element (1 = masked) |
| busy | output | 1 | Branch sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The assertions assume that `start` is a clean strobe sampled only on clock edges and that the command fields are steady in the cycle `start` is high. They also assume no element changes its word except through a broadcast edge. The bench drives all inputs on the falling edge and holds the fields until after the sampling edge. It sweeps every test code against a range of constants over a known ramp of words, and it keeps the stack depth inside its legal range, except in the two cases that deliberately overflow and underflow it. One case raises `start` during a running branch to show that it has no effect.

// File: rtl/simd_branch_seq_pkg.sv
package simd_branch_seq_pkg;

  typedef enum logic [2:0] {
    OP_KEEP = 3'd0,
    OP_LDI  = 3'd1,
    OP_LDX  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_XOR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } pe_op_e;

  typedef enum logic [1:0] {
    TST_EQ = 2'd0,
    TST_NE = 2'd1,
    TST_LT = 2'd2,
    TST_GE = 2'd3
  } pe_test_e;

  typedef enum logic [1:0] {
    CMD_EXEC   = 2'd0,
    CMD_BRANCH = 2'd1,
    CMD_PUSH   = 2'd2,
    CMD_POP    = 2'd3
  } seq_cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_TEST = 3'd1,
    PH_ARMA = 3'd2,
    PH_FLIP = 3'd3,
    PH_ARMB = 3'd4,
    PH_REST = 3'd5
  } seq_phase_e;

  typedef enum logic [1:0] {
    MA_HOLD = 2'd0,
    MA_TEST = 2'd1,
    MA_FLIP = 2'd2,
    MA_POP  = 2'd3
  } mask_act_e;

endpackage

// File: rtl/sbs_pe.sv
module sbs_pe
  import simd_branch_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  pe_op_e            op,
  input  logic [DATA_W-1:0] imm,
  input  pe_test_e          tst,
  input  logic [DATA_W-1:0] tst_imm,
  output logic [DATA_W-1:0] word,
  output logic              pass
);

  localparam logic [DATA_W-1:0] LANE_V = DATA_W'(LANE);

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    unique case (op)
      OP_LDI:  word_d = imm;
      OP_LDX:  word_d = imm + LANE_V;
      OP_ADD:  word_d = word_q + imm;
      OP_SUB:  word_d = word_q - imm;
      OP_XOR:  word_d = word_q ^ imm;
      default: word_d = word_q;
    endcase
  end

  always_comb begin
    unique case (tst)
      TST_EQ:  pass = (word_q == tst_imm);
      TST_NE:  pass = (word_q != tst_imm);
      TST_LT:  pass = (word_q <  tst_imm);
      default: pass = (word_q >= tst_imm);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (en) begin
      word_q <= word_d;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/sbs_mask_stack.sv
module sbs_mask_stack #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 4,
  localparam int DEP_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] top,
  output logic             full,
  output logic             empty,
  output logic [DEP_W-1:0] depth
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEP_W-1:0] depth_q;
  logic [DEP_W-1:0] depth_d;
  logic [DEP_W-1:0] top_ptr;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  assign full    = (depth_q == DEP_W'(DEPTH));
  assign empty   = (depth_q == '0);
  assign top_ptr = depth_q - DEP_W'(1);
  assign wr_ptr  = depth_q[PTR_W-1:0];
  assign rd_ptr  = top_ptr[PTR_W-1:0];
  assign top     = empty ? '0 : mem[rd_ptr];
  assign depth   = depth_q;

  always_comb begin
    depth_d = depth_q;
    if (push && !full) begin
      depth_d = depth_q + DEP_W'(1);
    end else if (pop && !empty) begin
      depth_d = top_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else if ((push && !full) || (pop && !empty)) begin
      depth_q <= depth_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[wr_ptr] <= din;
    end
  end

endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import simd_branch_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  seq_cmd_e  cmd,
  input  logic      stk_full,
  input  logic      stk_empty,
  output logic      idle,
  output logic      cap_en,
  output logic      op_go,
  output logic      op_second,
  output mask_act_e mask_act,
  output logic      push,
  output logic      pop,
  output logic      err_set,
  output logic      busy,
  output logic      done
);

  seq_phase_e phase_q;
  seq_phase_e phase_d;
  logic       done_q;
  logic       done_d;

  always_comb begin
    phase_d   = phase_q;
    cap_en    = 1'b0;
    op_go     = 1'b0;
    op_second = 1'b0;
    mask_act  = MA_HOLD;
    push      = 1'b0;
    pop       = 1'b0;
    err_set   = 1'b0;
    done_d    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          unique case (cmd)
            CMD_EXEC: begin
              op_go  = 1'b1;
              done_d = 1'b1;
            end
            CMD_BRANCH: begin
              if (stk_full) begin
                err_set = 1'b1;
                done_d  = 1'b1;
              end else begin
                cap_en  = 1'b1;
                phase_d = PH_TEST;
              end
            end
            CMD_PUSH: begin
              done_d = 1'b1;
              if (stk_full) begin
                err_set = 1'b1;
              end else begin
                push     = 1'b1;
                mask_act = MA_TEST;
              end
            end
            default: begin
              done_d = 1'b1;
              if (stk_empty) begin
                err_set = 1'b1;
              end else begin
                pop      = 1'b1;
                mask_act = MA_POP;
              end
            end
          endcase
        end
      end
      PH_TEST: begin
        push     = 1'b1;
        mask_act = MA_TEST;
        phase_d  = PH_ARMA;
      end
      PH_ARMA: begin
        op_go   = 1'b1;
        phase_d = PH_FLIP;
      end
      PH_FLIP: begin
        mask_act = MA_FLIP;
        phase_d  = PH_ARMB;
      end
      PH_ARMB: begin
        op_go     = 1'b1;
        op_second = 1'b1;
        phase_d   = PH_REST;
      end
      default: begin
        pop      = 1'b1;
        mask_act = MA_POP;
        done_d   = 1'b1;
        phase_d  = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign idle = (phase_q == PH_IDLE);
  assign busy = !idle;
  assign done = done_q;

endmodule

// File: rtl/simd_branch_seq.sv
module simd_branch_seq
  import simd_branch_seq_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int DATA_W = 8,
  parameter int STK_D  = 4,
  localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cmd,
  input  logic [1:0]        cond_sel,
  input  logic [DATA_W-1:0] cond_imm,
  input  logic [2:0]        then_op,
  input  logic [2:0]        else_op,
  input  logic [DATA_W-1:0] op_imm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_masked,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int DEP_W = $clog2(STK_D + 1);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic       idle, cap_en, op_go, op_second, push, pop, err_set;
  mask_act_e  mask_act;
  logic       stk_full, stk_empty;
  logic [NUM_PE-1:0] stk_top;
  logic [DEP_W-1:0]  stk_depth;

  pe_test_e          tst_q;
  logic [DATA_W-1:0] tst_imm_q;
  pe_op_e            opa_q, opb_q;
  logic [DATA_W-1:0] imm_q;

  pe_test_e          tst_cur;
  logic [DATA_W-1:0] tst_imm_cur;
  pe_op_e            op_cur;
  logic [DATA_W-1:0] imm_cur;

  logic [NUM_PE-1:0] mask_q, mask_d, pass_v, pe_en;
  logic [NUM_PE*DATA_W-1:0] words_flat;
  logic err_q;

  sbs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .cmd       (seq_cmd_e'(cmd)),
    .stk_full  (stk_full),
    .stk_empty (stk_empty),
    .idle      (idle),
    .cap_en    (cap_en),
    .op_go     (op_go),
    .op_second (op_second),
    .mask_act  (mask_act),
    .push      (push),
    .pop       (pop),
    .err_set   (err_set),
    .busy      (busy),
    .done      (done)
  );

  sbs_mask_stack #(.WIDTH(NUM_PE), .DEPTH(STK_D)) u_stack (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (push),
    .pop   (pop),
    .din   (mask_q),
    .top   (stk_top),
    .full  (stk_full),
    .empty (stk_empty),
    .depth (stk_depth)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tst_q     <= TST_EQ;
      tst_imm_q <= '0;
      opa_q     <= OP_KEEP;
      opb_q     <= OP_KEEP;
      imm_q     <= '0;
    end else if (cap_en) begin
      tst_q     <= pe_test_e'(cond_sel);
      tst_imm_q <= cond_imm;
      opa_q     <= pe_op_e'(then_op);
      opb_q     <= pe_op_e'(else_op);
      imm_q     <= op_imm;
    end
  end

  always_comb begin
    tst_cur     = idle ? pe_test_e'(cond_sel) : tst_q;
    tst_imm_cur = idle ? cond_imm : tst_imm_q;
    imm_cur     = idle ? op_imm : imm_q;
    if (op_second) begin
      op_cur = opb_q;
    end else begin
      op_cur = idle ? pe_op_e'(then_op) : opa_q;
    end
  end

  assign pe_en = {NUM_PE{op_go}} & ~mask_q;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    sbs_pe #(.DATA_W(DATA_W), .LANE(g)) u_pe (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .en      (pe_en[g]),
      .op      (op_cur),
      .imm     (imm_cur),
      .tst     (tst_cur),
      .tst_imm (tst_imm_cur),
      .word    (words_flat[g*DATA_W +: DATA_W]),
      .pass    (pass_v[g])
    );
  end

  always_comb begin
    unique case (mask_act)
      MA_TEST: mask_d = mask_q | ~pass_v;
      MA_FLIP: mask_d = stk_top | ~mask_q;
      MA_POP:  mask_d = stk_top;
      default: mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q <= '0;
    end else if (mask_act != MA_HOLD) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_q <= 1'b0;
    end else if (err_set) begin
      err_q <= 1'b1;
    end
  end

  assign err       = err_q;
  assign rd_data   = words_flat[rd_idx*DATA_W +: DATA_W];
  assign rd_masked = mask_q[rd_idx];

endmodule

// File: rtl/simd_branch_seq_chk.sv
module simd_branch_seq_chk #(
  parameter int NUM_PE = 4,
  parameter int DATA_W = 8,
  parameter int STK_D  = 4,
  localparam int DEP_W = $clog2(STK_D + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     busy,
  input logic                     done,
  input logic                     err,
  input logic [NUM_PE-1:0]        mask_q,
  input logic [DEP_W-1:0]         stk_depth,
  input logic [NUM_PE*DATA_W-1:0] words_flat
);

  for (genvar g = 0; g < NUM_PE; g++) begin : g_lane
    // R2: a masked element keeps its word across the next edge
    p_masked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[g] |=> (words_flat[g*DATA_W +: DATA_W] == $past(words_flat[g*DATA_W +: DATA_W])));
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(mask_q));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= DEP_W'(STK_D));

endmodule

bind simd_branch_seq simd_branch_seq_chk #(
  .NUM_PE (NUM_PE),
  .DATA_W (DATA_W),
  .STK_D  (STK_D)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .mask_q     (mask_q),
  .stk_depth  (stk_depth),
  .words_flat (words_flat)
);

// File: tb/simd_branch_seq_tb.sv
module simd_branch_seq_tb_top;

  localparam int NPE = 4;
  localparam int DW  = 8;
  localparam int SD  = 4;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [1:0]    cmd;
  logic [1:0]    cond_sel;
  logic [DW-1:0] cond_imm;
  logic [2:0]    then_op;
  logic [2:0]    else_op;
  logic [DW-1:0] op_imm;
  logic [1:0]    rd_idx;
  logic [DW-1:0] rd_data;
  logic          rd_masked;
  logic          busy;
  logic          done;
  logic          err;

  int checks;
  int errors;
  int cycles;

  int m_word [NPE];
  int m_mask [NPE];
  int m_stk  [SD][NPE];
  int m_dep;
  int m_err;

  simd_branch_seq #(.NUM_PE(NPE), .DATA_W(DW), .STK_D(SD)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd       (cmd),
    .cond_sel  (cond_sel),
    .cond_imm  (cond_imm),
    .then_op   (then_op),
    .else_op   (else_op),
    .op_imm    (op_imm),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_masked (rd_masked),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int f_op(input int op, input int imm, input int w, input int idx);
    case (op)
      1: return imm & 255;
      2: return (imm + idx) & 255;
      3: return (w + imm) & 255;
      4: return (w - imm) & 255;
      5: return (w ^ imm) & 255;
      default: return w;
    endcase
  endfunction

  function automatic int f_tst(input int sel, input int ci, input int w);
    case (sel)
      0: return int'(w == ci);
      1: return int'(w != ci);
      2: return int'(w < ci);
      default: return int'(w >= ci);
    endcase
  endfunction

  // Model of one command; returns the expected completion latency in cycles
  function automatic int model(input int c, input int cs, input int ci,
                               input int ta, input int tb, input int imm);
    int lat;
    lat = 1;
    case (c)
      0: for (int i = 0; i < NPE; i++)
           if (m_mask[i] == 0) m_word[i] = f_op(ta, imm, m_word[i], i);
      1: if (m_dep == SD) m_err = 1;
         else begin
           lat = 6;
           for (int i = 0; i < NPE; i++)
             if (m_mask[i] == 0)
               m_word[i] = f_tst(cs, ci, m_word[i]) != 0 ?
                           f_op(ta, imm, m_word[i], i) : f_op(tb, imm, m_word[i], i);
         end
      2: if (m_dep == SD) m_err = 1;
         else begin
           for (int i = 0; i < NPE; i++) begin
             m_stk[m_dep][i] = m_mask[i];
             if (f_tst(cs, ci, m_word[i]) == 0) m_mask[i] = 1;
           end
           m_dep++;
         end
      default: if (m_dep == 0) m_err = 1;
         else begin
           m_dep--;
           for (int i = 0; i < NPE; i++) m_mask[i] = m_stk[m_dep][i];
         end
    endcase
    return lat;
  endfunction

  task automatic compare_all(input string req);
    for (int i = 0; i < NPE; i++) begin
      rd_idx = 2'(i);
      #0.5;
      chk({req, "/R11 word"}, int'(rd_data), m_word[i]);
      chk({req, "/R11 mask"}, int'(rd_masked), m_mask[i]);
    end
    chk({req, "/R10 err"}, int'(err), m_err);
  endtask

  task automatic issue(input string req, input int c, input int cs, input int ci,
                       input int ta, input int tb, input int imm);
    int lat;
    int exp_lat;
    @(negedge clk);
    cmd = 2'(c); cond_sel = 2'(cs); cond_imm = DW'(ci);
    then_op = 3'(ta); else_op = 3'(tb); op_imm = DW'(imm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_lat = model(c, cs, ci, ta, tb, imm);
    chk({req, "/R7 busy"}, int'(busy), int'(exp_lat == 6));
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk({req, "/R7 latency"}, lat, exp_lat);
    @(negedge clk);
    chk({req, "/R7 done pulse"}, int'(done), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NPE; i++) begin
      m_word[i] = 0;
      m_mask[i] = 0;
    end
    m_dep = 0;
    m_err = 0;
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0;
    start = 1'b0; cmd = '0; cond_sel = '0; cond_imm = '0;
    then_op = '0; else_op = '0; op_imm = '0; rd_idx = '0;
    do_reset();

    // R1: reset state
    compare_all("R1");
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);

    // R2, R3: every opcode broadcast to all elements
    issue("R3 ldx", 0, 0, 0, 2, 0, 40);
    compare_all("R3 ldx");
    for (int op = 0; op < 8; op++) begin
      issue("R2 exec", 0, 0, 0, op, 0, 17 * op + 200);
      compare_all("R3 op sweep");
    end

    // R4, R5, R6, R7: branch over every test code and a range of constants
    for (int sel = 0; sel < 4; sel++) begin
      for (int ci = 0; ci < 8; ci++) begin
        issue("R5 ramp", 0, 0, 0, 2, 0, 2);
        issue("R5 branch", 1, sel, ci, 3 + (ci % 3), (sel + ci) % 8, 9 + ci);
        compare_all("R4/R5/R6 branch");
      end
    end

    // R9: push narrows, execute respects mask, nested branch, pop restores
    issue("R9 ramp", 0, 0, 0, 2, 0, 10);
    issue("R9 push", 2, 2, 12, 0, 0, 0);
    compare_all("R9 push");
    issue("R2 masked exec", 0, 0, 0, 3, 0, 1);
    compare_all("R2 masked exec");
    issue("R5 nested", 1, 0, 11, 1, 1, 85);
    compare_all("R5/R6 nested");
    issue("R9 pop", 3, 0, 0, 0, 0, 0);
    compare_all("R9 pop");

    // R8: start during a running branch is ignored
    issue("R8 ramp", 0, 0, 0, 2, 0, 20);
    @(negedge clk);
    cmd = 2'd1; cond_sel = 2'd2; cond_imm = 8'd22;
    then_op = 3'd3; else_op = 3'd5; op_imm = 8'd7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    void'(model(1, 2, 22, 3, 5, 7));
    @(negedge clk);
    cmd = 2'd0; then_op = 3'd1; op_imm = 8'hAA; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 no extra busy", int'(busy), 0);
    compare_all("R8 ignored start");

    // R10: overflow
    for (int k = 0; k < SD; k++) issue("R10 fill", 2, 3, 0, 0, 0, 0);
    chk("R10 err before", int'(err), 0);
    issue("R10 push overflow", 2, 0, 99, 0, 0, 0);
    compare_all("R10 push overflow");
    issue("R10 branch overflow", 1, 3, 0, 1, 1, 77);
    compare_all("R10 branch overflow");

    // R10: underflow after a fresh reset
    do_reset();
    issue("R10 underflow", 3, 0, 0, 0, 0, 0);
    compare_all("R10 underflow");

    finish_run();
  end

endmodule